// File: doc/BRIEF.md
# Multi-Channel Memory-to-Memory Transfer Controller

This block moves data between two memory locations on behalf of several independent channels. Each channel holds a 32-bit source address, a 32-bit destination address, a 16-bit unit count and a mode word. When its selected trigger fires, a channel asks for the shared memory master port. A single engine then carries out one unit at a time: it reads from the source, keeps the value in an internal holding register, and writes it to the destination.

Each channel chooses its own trigger, its sequencing (one unit per trigger, a fixed block per trigger, or everything that remains), its unit size (byte, halfword or word), and whether each address steps up, steps down or stays fixed. On the final unit the channel gives a one-cycle end-of-transfer pulse. It then either disables itself or reloads its count, and it can also reload its start addresses. Channels are set up through a small write-only configuration port.

The lowest-numbered pending channel wins the bus. The winner is chosen only between units. A non-maskable event or an interrupt request holds off new units until it clears, and the transfer then resumes exactly where it stopped.

Top module: `dma_mc`

## Requirements
- R1: After a synchronous reset, mem_req and every eot bit are low and every channel is disabled, so no trigger input starts any bus activity until a mode word is written.
- R2: A configuration write with cfg_we high stores cfg_wdata into the register of channel cfg_ch chosen by cfg_reg: 0 = source address, 1 = destination address, 2 = unit count (bits 15:0), 3 = mode word. Writing an address or the count also stores it as the reload value.
- R3: Mode bit 0 enables the channel. Bits 2:1 choose the trigger: 0 = ext_req[ch] level, 1 = periph_irq[ch] level, 2 = software (mode bit 3, which clears itself when accepted). A trigger is accepted only while the channel is enabled, idle and has a nonzero count.
- R4: Sequence field bits 5:4 = 0 (step): each accepted trigger moves exactly one unit.
- R5: Sequence field = 1 (block): each accepted trigger moves BLK_LEN units, or fewer if the count runs out first.
- R6: Sequence field = 2 (burst): one accepted trigger moves every remaining unit.
- R7: Each unit is a read at the source address followed by a write at the destination address, carrying the read data. Data is right-aligned on mem_rdata/mem_wdata. Size field bits 7:6 (0 = byte, 1 = halfword, 2 = word) appears on mem_size and sets the address step to 1, 2 or 4 bytes. Address mode fields (source bits 9:8, destination bits 11:10) select 0 = fixed, 1 = increment, 2 = decrement.
- R8: On the write handshake of the unit that takes the count to zero, the channel's eot bit goes high for exactly the following cycle. If count reload (mode bit 13) is off, the channel is disabled and later triggers are ignored.
- R9: With count reload on, the count returns to its programmed value and the channel stays enabled. With address reload (mode bit 12) on, both addresses return to their programmed start values.
- R10: When several channels are pending, the lowest-numbered one gets the next unit. A unit in progress is never preempted.
- R11: While nmi or irq_req is high, no new unit starts. Once both are low, the transfer resumes with no unit lost or repeated.
- R12: While bus_grant is low, no new unit starts.
- R13: A channel whose count is zero never starts a transfer.
- R14: While mem_req is high and mem_ready is low, mem_addr, mem_we and mem_req hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_reg | input | 2 | Register select within the channel |
| cfg_wdata | input | 32 | Configuration write data |
| ext_req | input | N_CH | External request level, one per channel |
| periph_irq | input | N_CH | Peripheral interrupt request, one per channel |
| nmi | input | 1 | Non-maskable suspend |
| irq_req | input | 1 | Enabled interrupt request, suspends |
| bus_grant | input | 1 | Bus granted to this controller |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_ready | input | 1 | Access completes on this cycle |
| eot | output | N_CH | End-of-transfer pulse per channel |

## Verification
The hardest case to reach from the ports is a lower-numbered channel becoming pending while a higher-numbered channel's unit is still in flight. The bench creates it by toggling mem_ready so that every access stretches, then triggering channel 3 and, two cycles later, channel 1. The write log must then show one unit of channel 3, both units of channel 1, and then the rest of channel 3. Suspension in the middle of a burst is the other hard case. The bench raises nmi, and in a second pass irq_req, after a fixed number of units and checks that the bus stays idle. After release it compares the finished destination against the source pattern byte by byte, which shows that no unit was lost or repeated.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {TRG_EXT = 2'd0, TRG_PERIPH = 2'd1, TRG_SW = 2'd2, TRG_NONE = 2'd3} trig_e;
    typedef enum logic [1:0] {SEQ_STEP = 2'd0, SEQ_BLOCK = 2'd1, SEQ_BURST = 2'd2, SEQ_RSVD = 2'd3} seq_e;
    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} size_e;
    typedef enum logic [1:0] {AM_FIXED = 2'd0, AM_INC = 2'd1, AM_DEC = 2'd2, AM_RSVD = 2'd3} amode_e;
    typedef enum logic [1:0] {CREG_SRC = 2'd0, CREG_DST = 2'd1, CREG_CNT = 2'd2, CREG_MODE = 2'd3} creg_e;
    typedef enum logic [1:0] {ENG_IDLE = 2'd0, ENG_READ = 2'd1, ENG_WRITE = 2'd2} eng_e;

    // Mode word, bit 0 at the bottom
    typedef struct packed {
        logic   cnt_reload;   // 13
        logic   addr_reload;  // 12
        amode_e dst_am;       // 11:10
        amode_e src_am;       // 9:8
        size_e  size;         // 7:6
        seq_e   seq;          // 5:4
        logic   sw_go;        // 3
        trig_e  trig;         // 2:1
        logic   en;           // 0
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic logic [ADDR_W-1:0] unit_bytes(input size_e s);
        case (s)
            SZ_BYTE: return ADDR_W'(1);
            SZ_HALF: return ADDR_W'(2);
            default: return ADDR_W'(4);
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a,
                                                    input amode_e m, input size_e s);
        case (m)
            AM_INC:  return a + unit_bytes(s);
            AM_DEC:  return a - unit_bytes(s);
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter  int BLK_LEN = 4,
    localparam int BLK_W   = $clog2(BLK_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  creg_e             cfg_reg,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              ext_req,
    input  logic              periph_irq,
    input  logic              unit_done,
    output logic              pend,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output size_e             unit_size,
    output logic              eot
);

    mode_t             mode;
    logic [ADDR_W-1:0] src_q, dst_q, src_start, dst_start;
    logic [CNT_W-1:0]  cnt_q, cnt_start;
    logic [BLK_W-1:0]  blk_left;
    logic              active;
    logic              trig_hit, start, last_unit, sess_end;

    always_comb begin
        case (mode.trig)
            TRG_EXT:    trig_hit = ext_req;
            TRG_PERIPH: trig_hit = periph_irq;
            TRG_SW:     trig_hit = mode.sw_go;
            default:    trig_hit = 1'b0;
        endcase
    end

    assign start     = mode.en && !active && (cnt_q != '0) && trig_hit;
    assign last_unit = (cnt_q == CNT_W'(1));
    assign sess_end  = last_unit || (mode.seq == SEQ_STEP) ||
                       ((mode.seq == SEQ_BLOCK) && (blk_left == BLK_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= '0;
            src_q     <= '0;
            dst_q     <= '0;
            src_start <= '0;
            dst_start <= '0;
            cnt_q     <= '0;
            cnt_start <= '0;
            blk_left  <= '0;
            active    <= 1'b0;
            eot       <= 1'b0;
        end else begin
            eot <= 1'b0;
            if (unit_done) begin
                src_q    <= addr_next(src_q, mode.src_am, mode.size);
                dst_q    <= addr_next(dst_q, mode.dst_am, mode.size);
                cnt_q    <= cnt_q - CNT_W'(1);
                blk_left <= blk_left - BLK_W'(1);
                if (sess_end)
                    active <= 1'b0;
                if (last_unit) begin
                    eot <= 1'b1;
                    if (mode.cnt_reload)
                        cnt_q <= cnt_start;
                    else
                        mode.en <= 1'b0;
                    if (mode.addr_reload) begin
                        src_q <= src_start;
                        dst_q <= dst_start;
                    end
                end
            end else if (start) begin
                active      <= 1'b1;
                blk_left    <= BLK_W'(BLK_LEN);
                mode.sw_go  <= 1'b0;
            end
            if (cfg_we) begin
                case (cfg_reg)
                    CREG_SRC:  begin src_q <= cfg_wdata; src_start <= cfg_wdata; end
                    CREG_DST:  begin dst_q <= cfg_wdata; dst_start <= cfg_wdata; end
                    CREG_CNT:  begin cnt_q <= cfg_wdata[CNT_W-1:0]; cnt_start <= cfg_wdata[CNT_W-1:0]; end
                    default:   mode <= mode_t'(cfg_wdata[MODE_W-1:0]);
                endcase
            end
        end
    end

    assign pend      = active;
    assign src_addr  = src_q;
    assign dst_addr  = dst_q;
    assign unit_size = mode.size;

    // R8
    eot_after_unit_chk: assert property (@(posedge clk) disable iff (rst)
        eot |-> $past(unit_done));

    // R13
    no_zero_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> ($past(cnt_q) != '0));

    // R3
    start_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(mode.en));

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
    parameter  int N_CH = 5,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] req,
    output logic            any,
    output logic [CH_W-1:0] idx
);

    logic [N_CH-1:0] win_oh;

    always_comb begin
        any    = |req;
        idx    = '0;
        win_oh = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx    = CH_W'(i);
                win_oh = N_CH'(1) << i;
            end
        end
    end

    // R10
    always_comb begin
        if (any) begin
            prio_lowest_chk: assert (((req & (win_oh - N_CH'(1))) == '0) && ((req & win_oh) != '0));
        end
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter  int N_CH = 5,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_any,
    input  logic [CH_W-1:0]   req_idx,
    input  logic              suspend,
    input  logic              bus_grant,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  size_e             size,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CH_W-1:0]   cur_idx,
    output logic              unit_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    eng_e              state;
    logic [CH_W-1:0]   cur_q;
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            cur_q  <= '0;
            hold_q <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (req_any && bus_grant && !suspend) begin
                        cur_q <= req_idx;
                        state <= ENG_READ;
                    end
                end
                ENG_READ: begin
                    if (mem_ready) begin
                        hold_q <= mem_rdata;
                        state  <= ENG_WRITE;
                    end
                end
                ENG_WRITE: begin
                    if (mem_ready)
                        state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign cur_idx   = cur_q;
    assign unit_done = (state == ENG_WRITE) && mem_ready;
    assign mem_req   = (state != ENG_IDLE);
    assign mem_we    = (state == ENG_WRITE);
    assign mem_addr  = (state == ENG_WRITE) ? dst_addr : src_addr;
    assign mem_size  = size;
    assign mem_wdata = hold_q;

    // R7
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

    // R7
    wdata_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready) |=> (mem_wdata == $past(mem_rdata)));

    // R10
    unit_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ready) |=> !mem_req);

    // R11
    suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (suspend && !mem_req) |=> !mem_req);

    // R12
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_grant && !mem_req) |=> !mem_req);

    // R14
    wait_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: rtl/dma_mc.sv
module dma_mc
    import dma_pkg::*;
#(
    parameter  int N_CH    = 5,
    parameter  int BLK_LEN = 4,
    localparam int CH_W    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_reg,
    input  logic [31:0]       cfg_wdata,
    input  logic [N_CH-1:0]   ext_req,
    input  logic [N_CH-1:0]   periph_irq,
    input  logic              nmi,
    input  logic              irq_req,
    input  logic              bus_grant,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic [N_CH-1:0]   eot
);

    logic [N_CH-1:0]   pend;
    logic [N_CH-1:0]   done_vec;
    logic [ADDR_W-1:0] src_a [N_CH];
    logic [ADDR_W-1:0] dst_a [N_CH];
    size_e             size_a [N_CH];
    logic              req_any, unit_done;
    logic [CH_W-1:0]   req_idx, cur_idx;

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        dma_chan #(.BLK_LEN(BLK_LEN)) i_chan (
            .clk        (clk),
            .rst        (rst),
            .cfg_we     (cfg_we && (cfg_ch == CH_W'(c))),
            .cfg_reg    (creg_e'(cfg_reg)),
            .cfg_wdata  (cfg_wdata),
            .ext_req    (ext_req[c]),
            .periph_irq (periph_irq[c]),
            .unit_done  (done_vec[c]),
            .pend       (pend[c]),
            .src_addr   (src_a[c]),
            .dst_addr   (dst_a[c]),
            .unit_size  (size_a[c]),
            .eot        (eot[c])
        );
    end

    dma_arb #(.N_CH(N_CH)) i_arb (
        .req (pend),
        .any (req_any),
        .idx (req_idx)
    );

    assign done_vec = unit_done ? (N_CH'(1) << cur_idx) : '0;

    dma_engine #(.N_CH(N_CH)) i_engine (
        .clk       (clk),
        .rst       (rst),
        .req_any   (req_any),
        .req_idx   (req_idx),
        .suspend   (nmi || irq_req),
        .bus_grant (bus_grant),
        .src_addr  (src_a[cur_idx]),
        .dst_addr  (dst_a[cur_idx]),
        .size      (size_a[cur_idx]),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .cur_idx   (cur_idx),
        .unit_done (unit_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_size  (mem_size),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R8
    eot_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eot));

endmodule

// File: tb/test_dma_mc.sv
module test_dma_mc;

    localparam int NCH = 5;
    localparam int BLK = 4;
    localparam int T_EXT = 0, T_PER = 1, T_SW = 2;
    localparam int S_STEP = 0, S_BLOCK = 1, S_BURST = 2;
    localparam int A_FIX = 0, A_INC = 1, A_DEC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_ch = '0;
    logic [1:0] cfg_reg = '0;
    logic [31:0] cfg_wdata = '0;
    logic [NCH-1:0] ext_req = '0;
    logic [NCH-1:0] periph_irq = '0;
    logic nmi = 1'b0, irq_req = 1'b0, bus_grant = 1'b1;
    logic mem_req, mem_we, mem_ready;
    logic [1:0] mem_size;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [NCH-1:0] eot;

    logic wait_en = 1'b0, tog = 1'b0, do_init = 1'b0;
    logic [7:0] mem [256];
    int wr_cnt = 0;
    int eot_cnt [NCH] = '{default: 0};
    logic [31:0] wlog [128];
    int n_chk = 0, n_fail = 0;
    logic timed_out = 1'b0;

    always #5 clk = ~clk;

    dma_mc #(.N_CH(NCH), .BLK_LEN(BLK)) i_dma_mc (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_reg(cfg_reg),
        .cfg_wdata(cfg_wdata), .ext_req(ext_req), .periph_irq(periph_irq), .nmi(nmi),
        .irq_req(irq_req), .bus_grant(bus_grant), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .eot(eot)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // memory model
    assign mem_ready = !wait_en || tog;
    always_comb begin
        mem_rdata = {mem[mem_addr[7:0] + 8'd3], mem[mem_addr[7:0] + 8'd2],
                     mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
    end
    always @(posedge clk) begin
        tog <= ~tog;
        if (do_init) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
        end else if (mem_req && mem_we && mem_ready) begin
            mem[mem_addr[7:0]] <= mem_wdata[7:0];
            if (mem_size != 2'd0) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
            if (mem_size == 2'd2) begin
                mem[mem_addr[7:0] + 8'd2] <= mem_wdata[23:16];
                mem[mem_addr[7:0] + 8'd3] <= mem_wdata[31:24];
            end
            wlog[wr_cnt & 127] <= mem_addr;
            wr_cnt <= wr_cnt + 1;
        end
        for (int c = 0; c < NCH; c++) if (eot[c]) eot_cnt[c] <= eot_cnt[c] + 1;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int trig, input int sw, input int seq, input int sz,
                                       input int sam, input int dam, input int ar, input int cr);
        return 32'(1 | (trig << 1) | (sw << 3) | (seq << 4) | (sz << 6) |
                   (sam << 8) | (dam << 10) | (ar << 12) | (cr << 13));
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcfg(input int ch, input int r, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_reg = 2'(r); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                         input int n, input logic [31:0] m);
        wcfg(ch, 0, s); wcfg(ch, 1, d); wcfg(ch, 2, 32'(n)); wcfg(ch, 3, m);
    endtask

    task automatic init_mem();
        @(negedge clk); do_init = 1'b1;
        @(negedge clk); do_init = 1'b0;
    endtask

    task automatic pulse_ext(input int ch);
        @(negedge clk); ext_req[ch] = 1'b1;
        @(negedge clk); ext_req[ch] = 1'b0;
    endtask

    task automatic pulse_per(input int ch);
        @(negedge clk); periph_irq[ch] = 1'b1;
        @(negedge clk); periph_irq[ch] = 1'b0;
    endtask

    // count bytes that differ from the source pattern over n units
    function automatic int cmp_units(input int s0, input int sdir, input int d0, input int ddir,
                                     input int b, input int n);
        int bad = 0;
        for (int k = 0; k < n; k++)
            for (int j = 0; j < b; j++)
                if (mem[(d0 + ddir * k * b + j) & 255] != pat((s0 + sdir * k * b + j) & 255)) bad++;
        return bad;
    endfunction

    task automatic run_all();
        int base, eb, w1;
        // reset state R1
        cyc(4);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mem_req after reset", mem_req, 0);
        chk("R1 eot after reset", eot, 0);
        ext_req = '1; periph_irq = '1;
        cyc(10);
        ext_req = '0; periph_irq = '0;
        chk("R1 disabled channels ignore triggers", wr_cnt, 0);

        // step sequencing, external trigger: R2 R3 R4 R8
        init_mem();
        setup(0, 32'h00, 32'h80, 3, mk(T_EXT, 0, S_STEP, 2, A_INC, A_INC, 0, 0));
        base = wr_cnt; eb = eot_cnt[0];
        for (int k = 1; k <= 3; k++) begin
            pulse_ext(0);
            cyc(20);
            chk("R4 one unit per trigger", wr_cnt - base, k);
        end
        chk("R8 eot pulse count ch0", eot_cnt[0] - eb, 1);
        chk("R2 R7 step data", cmp_units(0, 1, 32'h80, 1, 4, 3), 0);
        pulse_ext(0);
        cyc(20);
        chk("R8 disabled after completion", wr_cnt - base, 3);
        chk("R8 byte past end untouched", mem[8'h8C], pat(8'h8C));

        // burst sweep over size and source direction: R3 R6 R7
        for (int sz = 0; sz < 3; sz++) begin
            for (int sd = 0; sd < 2; sd++) begin
                int b, s0;
                b = 1 << sz;
                s0 = (sd == 1) ? (8'h30 + 3 * b) : 8'h30;
                init_mem();
                base = wr_cnt; eb = eot_cnt[1];
                setup(1, 32'(s0), 32'h90, 4, mk(T_SW, 1, S_BURST, sz, (sd == 1) ? A_DEC : A_INC, A_INC, 0, 0));
                cyc(40);
                chk("R6 burst moves all units", wr_cnt - base, 4);
                chk("R7 size/direction data", cmp_units(s0, (sd == 1) ? -1 : 1, 32'h90, 1, b, 4), 0);
                chk("R7 last destination address", wlog[(base + 3) & 127], 32'h90 + 3 * b);
                chk("R8 eot once per burst", eot_cnt[1] - eb, 1);
            end
        end

        // block sequencing with reloads, peripheral trigger: R3 R5 R9
        init_mem();
        setup(2, 32'h00, 32'hA0, 6, mk(T_PER, 0, S_BLOCK, 1, A_INC, A_INC, 1, 1));
        base = wr_cnt; eb = eot_cnt[2];
        pulse_per(2); cyc(30);
        chk("R5 full block", wr_cnt - base, 4);
        pulse_per(2); cyc(30);
        chk("R5 short tail block", wr_cnt - base, 6);
        chk("R5 eot at count end", eot_cnt[2] - eb, 1);
        chk("R5 block data", cmp_units(0, 1, 32'hA0, 1, 2, 6), 0);
        pulse_per(2); cyc(30);
        chk("R9 count reload keeps enabled", wr_cnt - base, 10);
        chk("R9 address reload", wlog[(base + 6) & 127], 32'hA0);
        pulse_per(2); cyc(30);
        chk("R9 reloaded count ends again", eot_cnt[2] - eb, 2);

        // fixed destination: R7
        init_mem();
        base = wr_cnt;
        setup(3, 32'h00, 32'hF0, 3, mk(T_SW, 1, S_BURST, 0, A_INC, A_FIX, 0, 0));
        cyc(30);
        chk("R7 fixed address first", wlog[base & 127], 32'hF0);
        chk("R7 fixed address last", wlog[(base + 2) & 127], 32'hF0);
        chk("R7 fixed holds last unit", mem[8'hF0], pat(2));

        // priority at unit boundaries with wait states: R10 R14
        init_mem();
        setup(3, 32'h00, 32'hC0, 3, mk(T_EXT, 0, S_BURST, 2, A_INC, A_INC, 0, 0));
        setup(1, 32'h40, 32'h80, 2, mk(T_EXT, 0, S_BURST, 2, A_INC, A_INC, 0, 0));
        wait_en = 1'b1;
        base = wr_cnt;
        pulse_ext(3);
        pulse_ext(1);
        cyc(80);
        wait_en = 1'b0;
        chk("R10 total units", wr_cnt - base, 5);
        chk("R10 unit in flight finishes", wlog[base & 127], 32'hC0);
        chk("R10 lower channel next", wlog[(base + 1) & 127], 32'h80);
        chk("R10 lower channel drains", wlog[(base + 2) & 127], 32'h84);
        chk("R10 higher channel resumes", wlog[(base + 3) & 127], 32'hC4);
        chk("R14 data under wait states ch3", cmp_units(0, 1, 32'hC0, 1, 4, 3), 0);
        chk("R14 data under wait states ch1", cmp_units(32'h40, 1, 32'h80, 1, 4, 2), 0);

        // suspension by nmi then irq_req: R11
        for (int which = 0; which < 2; which++) begin
            init_mem();
            base = wr_cnt; eb = eot_cnt[4];
            setup(4, 32'h00, 32'h60, 10, mk(T_SW, 1, S_BURST, 0, A_INC, A_INC, 0, 0));
            cyc(7);
            if (which == 0) nmi = 1'b1; else irq_req = 1'b1;
            cyc(4);
            w1 = wr_cnt - base;
            chk("R11 bus idle while suspended", mem_req, 0);
            cyc(20);
            chk("R11 no progress while suspended", wr_cnt - base, w1);
            chk("R11 suspended mid-transfer", (w1 > 0 && w1 < 10) ? 1 : 0, 1);
            nmi = 1'b0; irq_req = 1'b0;
            cyc(60);
            chk("R11 resumed to completion", wr_cnt - base, 10);
            chk("R11 no unit lost or repeated", cmp_units(0, 1, 32'h60, 1, 1, 10), 0);
            chk("R11 single eot", eot_cnt[4] - eb, 1);
        end

        // grant withheld: R12
        init_mem();
        bus_grant = 1'b0;
        base = wr_cnt;
        setup(0, 32'h00, 32'h80, 2, mk(T_SW, 1, S_BURST, 2, A_INC, A_INC, 0, 0));
        cyc(20);
        chk("R12 no unit without grant", wr_cnt - base, 0);
        chk("R12 no request without grant", mem_req, 0);
        bus_grant = 1'b1;
        cyc(20);
        chk("R12 proceeds after grant", wr_cnt - base, 2);

        // zero count: R13
        base = wr_cnt; eb = eot_cnt[0];
        setup(0, 32'h00, 32'h80, 0, mk(T_SW, 1, S_BURST, 2, A_INC, A_INC, 0, 0));
        cyc(20);
        chk("R13 zero count never starts", wr_cnt - base, 0);
        chk("R13 zero count no eot", eot_cnt[0] - eb, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule